// File: doc/BRIEF.md
# Minimum-SAD Tracker for Variable Block Size Motion Estimation

This block sits behind an array of sixteen processing groups that evaluate sixteen horizontally adjacent search candidates at once. On each row of the sixteen-row candidate period, the groups deliver the distortion values of the sub-blocks that complete in that row. The tracker reduces each set of sixteen values with a comparator tree, which picks the smallest value and the group that produced it. It then keeps, for each of the 41 sub-blocks of a 16x16 macroblock, the smallest distortion seen so far and the motion vector where it was found.

Only sixteen comparator trees exist. Sub-blocks of one shape complete in different rows, so each tree serves several sub-blocks in turn. The recent-minimum registers are shared by all groups, and each tree updates them only in the rows where its inputs are fresh. An internal candidate sequencer counts rows, batches and horizontal phases. From these counts it derives the coordinates of every candidate in the batch, so each motion vector is the batch origin plus the winning group index. A start pulse opens a macroblock. A done pulse marks the cycle in which all 41 results are final.

Top module: `smt_tracker`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it, every stored SAD is all ones, every motion vector component is zero and `done_o` is low.
- R2: A `start_i` pulse wins over `run_i`. In the next cycle all 41 stored SADs are all ones and all MVs are zero. The sequencer restarts at row 0 of the first batch, which is vertical offset 0 and phase 0.
- R3: Each cycle with the tracker busy, `run_i` high and `start_i` low advances one row, and a batch is 16 rows. The batch covers candidates x = -SRCH_W/2 + 16*phase + g for groups g = 0..15, at y = -SRCH_H/2 + offset. The offset steps once per batch through SRCH_H values, after which the phase steps through SRCH_W/16 values. A cycle with `run_i` low changes nothing.
- R4: The 4x4 and 8x4 trees sample on rows 3, 7, 11 and 15, serving slot row/4. The 4x8, 8x8 and 16x8 trees sample on rows 7 and 15, serving slot row/8. The 8x16 and 16x16 trees sample on row 15 only. SAD inputs on any other row have no effect on the outputs.
- R5: On each shape bus, the SAD of tree j from group g sits at bits (j*16+g)*SAD_W and upward. Tree j with slot s serves the block at index base + s*trees + j.
- R6: Output block indices are as follows. 4x4: 0-15, in raster order. 8x4: 16-23. 4x8: 24-31. 8x8: 32-35. 16x8: 36-37. 8x16: 38-39. 16x16: 40. Block b uses bits b*SAD_W of `min_sad_o` and bits b*MVW of each MV bus.
- R7: A stored SAD and MV are replaced only when the tree's minimum is strictly smaller than the stored SAD. An equal value keeps the earlier candidate.
- R8: When several groups in one tree give the same minimum, the lowest group index wins.
- R9: `done_o` is a one-cycle pulse in the cycle after row 15 of the last batch is accepted, and the outputs then hold the final minima.
- R10: After done and until the next start, `run_i` and the SAD inputs have no effect, and the outputs stay constant.
- R11: Outside a start, no stored SAD ever increases, and every x component stays within -SRCH_W/2..SRCH_W/2-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of macroblock: clear minima, restart sequence |
| run_i | input | 1 | Advance one row this cycle |
| sad_4x4_i | input | 4*NG*SAD_W | 4x4 SADs, four trees by sixteen groups |
| sad_8x4_i | input | 2*NG*SAD_W | 8x4 SADs, two trees |
| sad_4x8_i | input | 4*NG*SAD_W | 4x8 SADs, four trees |
| sad_8x8_i | input | 2*NG*SAD_W | 8x8 SADs, two trees |
| sad_16x8_i | input | NG*SAD_W | 16x8 SADs, one tree |
| sad_8x16_i | input | 2*NG*SAD_W | 8x16 SADs, two trees |
| sad_16x16_i | input | NG*SAD_W | 16x16 SADs, one tree |
| done_o | output | 1 | All 41 results final (one-cycle pulse) |
| min_sad_o | output | 41*SAD_W | Recent minimum SAD for each block |
| min_mvx_o | output | 41*MVW | Signed horizontal MV for each block |
| min_mvy_o | output | 41*MVW | Signed vertical MV for each block |

## Verification
The bench runs four input patterns, and each one isolates a different part of the update logic.

- **Constant SADs on every lane.** No later candidate can win, so every block must report the very first candidate. This separates the strict-less update rule and the lowest-group tie rule from any looser comparison.
- **Narrow-range random values with stalls on `run_i`.** Ties between groups and between batches are frequent, which exposes off-by-one faults in candidate coordinates and in stall handling.
- **Wide random values with zeros driven on every lane outside its sampling row.** Only correct slot timing keeps those zeros out of the minima, so wrong slot or lane selection shows up.
- **Restart in mid-macroblock, followed by extra run cycles after done.** This checks that a start clears the minima and that the outputs stay frozen once the tracker is idle.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int MB_ROWS = 16;
  localparam int ROW_W   = $clog2(MB_ROWS);
  localparam int NUM_BLK = 41;

  // Sampling cadence of a shape class: every 4, every 8 or every 16 rows.
  typedef enum logic [1:0] {
    CAD_4  = 2'd0,
    CAD_8  = 2'd1,
    CAD_16 = 2'd2
  } cadence_e;

  // Base block index of each shape class in the output vectors.
  localparam int BASE_4X4   = 0;
  localparam int BASE_8X4   = 16;
  localparam int BASE_4X8   = 24;
  localparam int BASE_8X8   = 32;
  localparam int BASE_16X8  = 36;
  localparam int BASE_8X16  = 38;
  localparam int BASE_16X16 = 40;
endpackage

// File: rtl/smt_cmp_tree.sv
module smt_cmp_tree #(
  parameter int NG = 16,
  parameter int W  = 16
) (
  input  logic [NG*W-1:0]         sad_i,
  output logic [W-1:0]            min_o,
  output logic [$clog2(NG)-1:0]   idx_o
);
  localparam int IW    = $clog2(NG);
  localparam int NODES = 2*NG - 1;

  logic [W-1:0]  nv [NODES];
  logic [IW-1:0] ni [NODES];

  // Leaves: heap positions NG-1 .. 2*NG-2 hold groups 0 .. NG-1.
  for (genvar g = 0; g < NG; g++) begin : g_leaf
    assign nv[NG-1+g] = sad_i[g*W +: W];
    assign ni[NG-1+g] = IW'(g);
  end

  // Internal nodes: the left child covers the lower group indices,
  // so the right child wins only when strictly smaller.
  for (genvar i = 0; i < NG-1; i++) begin : g_node
    logic take_r;
    assign take_r = nv[2*i+2] < nv[2*i+1];
    assign nv[i]  = take_r ? nv[2*i+2] : nv[2*i+1];
    assign ni[i]  = take_r ? ni[2*i+2] : ni[2*i+1];
  end

  assign min_o = nv[0];
  assign idx_o = ni[0];
endmodule

// File: rtl/smt_cand_seq.sv
module smt_cand_seq
  import smt_pkg::*;
#(
  parameter int NG     = 16,
  parameter int SRCH_W = 48,
  parameter int SRCH_H = 32,
  parameter int MVW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  run_i,
  output logic                  step_o,
  output logic [ROW_W-1:0]      row_o,
  output logic signed [MVW-1:0] base_x_o,
  output logic signed [MVW-1:0] base_y_o,
  output logic                  done_o
);
  localparam int NPH = SRCH_W / NG;
  localparam int VW  = (SRCH_H > 1) ? $clog2(SRCH_H) : 1;
  localparam int PW  = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic signed [MVW-1:0] X0 = MVW'(-(SRCH_W/2));
  localparam logic signed [MVW-1:0] Y0 = MVW'(-(SRCH_H/2));

  logic             busy_q, busy_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [VW-1:0]    vy_q, vy_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic             done_q, done_d;
  logic             step, row_end, col_end, ph_end, st_en;

  assign step    = busy_q & run_i & ~start_i;
  assign row_end = row_q == ROW_W'(MB_ROWS-1);
  assign col_end = vy_q == VW'(SRCH_H-1);
  assign ph_end  = ph_q == PW'(NPH-1);
  assign st_en   = start_i | step;

  always_comb begin
    busy_d = busy_q;
    row_d  = row_q;
    vy_d   = vy_q;
    ph_d   = ph_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      row_d  = '0;
      vy_d   = '0;
      ph_d   = '0;
    end else if (step) begin
      row_d = row_end ? '0 : row_q + 1'b1;
      if (row_end) begin
        if (col_end) begin
          vy_d = '0;
          if (ph_end) begin
            ph_d   = '0;
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end else begin
          vy_d = vy_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      vy_q   <= '0;
      ph_q   <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      row_q  <= row_d;
      vy_q   <= vy_d;
      ph_q   <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign step_o   = step;
  assign row_o    = row_q;
  assign base_x_o = X0 + MVW'(int'(ph_q) * NG);
  assign base_y_o = Y0 + MVW'(vy_q);
  assign done_o   = done_q;
endmodule

// File: rtl/smt_shape_unit.sv
module smt_shape_unit
  import smt_pkg::*;
#(
  parameter int       NG  = 16,
  parameter int       W   = 16,
  parameter int       MVW = 8,
  parameter int       NT  = 4,
  parameter cadence_e CAD = CAD_4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     step_i,
  input  logic [ROW_W-1:0]         row_i,
  input  logic signed [MVW-1:0]    base_x_i,
  input  logic signed [MVW-1:0]    base_y_i,
  input  logic [NT*NG*W-1:0]       sad_i,
  output logic [NT*(MB_ROWS/(4*(1<<CAD)))*W-1:0]   min_sad_o,
  output logic [NT*(MB_ROWS/(4*(1<<CAD)))*MVW-1:0] min_mvx_o,
  output logic [NT*(MB_ROWS/(4*(1<<CAD)))*MVW-1:0] min_mvy_o
);
  localparam int NSLOT = MB_ROWS / (4 * (1 << CAD));
  localparam int NE    = NT * NSLOT;
  localparam int IW    = $clog2(NG);

  logic       fire;
  logic [1:0] slot;

  // Sampling row and slot for this cadence.
  if (CAD == CAD_4) begin : g_c4
    assign fire = step_i & (row_i[1:0] == 2'd3);
    assign slot = row_i[3:2];
  end else if (CAD == CAD_8) begin : g_c8
    assign fire = step_i & (row_i[2:0] == 3'd7);
    assign slot = {1'b0, row_i[3]};
  end else begin : g_c16
    assign fire = step_i & (row_i == 4'd15);
    assign slot = 2'd0;
  end

  logic [W-1:0]           win_sad [NT];
  logic [IW-1:0]          win_idx [NT];
  logic signed [MVW-1:0]  win_mvx [NT];

  for (genvar j = 0; j < NT; j++) begin : g_tree
    smt_cmp_tree #(.NG(NG), .W(W)) u_tree (
      .sad_i (sad_i[j*NG*W +: NG*W]),
      .min_o (win_sad[j]),
      .idx_o (win_idx[j])
    );
    assign win_mvx[j] = base_x_i + $signed({{(MVW-IW){1'b0}}, win_idx[j]});
  end

  logic [W-1:0]   sad_q [NE];
  logic [W-1:0]   sad_d [NE];
  logic [MVW-1:0] mvx_q [NE];
  logic [MVW-1:0] mvx_d [NE];
  logic [MVW-1:0] mvy_q [NE];
  logic [MVW-1:0] mvy_d [NE];
  logic           en;

  assign en = clr_i | fire;

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      sad_d[e] = sad_q[e];
      mvx_d[e] = mvx_q[e];
      mvy_d[e] = mvy_q[e];
      if (clr_i) begin
        sad_d[e] = '1;
        mvx_d[e] = '0;
        mvy_d[e] = '0;
      end else if (fire && (int'(slot) == e / NT) &&
                   (win_sad[e % NT] < sad_q[e])) begin
        sad_d[e] = win_sad[e % NT];
        mvx_d[e] = win_mvx[e % NT];
        mvy_d[e] = base_y_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        sad_q[e] <= '1;
        mvx_q[e] <= '0;
        mvy_q[e] <= '0;
      end
    end else if (en) begin
      for (int e = 0; e < NE; e++) begin
        sad_q[e] <= sad_d[e];
        mvx_q[e] <= mvx_d[e];
        mvy_q[e] <= mvy_d[e];
      end
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_out
    assign min_sad_o[e*W +: W]     = sad_q[e];
    assign min_mvx_o[e*MVW +: MVW] = mvx_q[e];
    assign min_mvy_o[e*MVW +: MVW] = mvy_q[e];
  end
endmodule

// File: rtl/smt_tracker.sv
module smt_tracker
  import smt_pkg::*;
#(
  parameter int NG     = 16,
  parameter int SAD_W  = 16,
  parameter int MVW    = 8,
  parameter int SRCH_W = 48,
  parameter int SRCH_H = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     run_i,
  input  logic [4*NG*SAD_W-1:0]    sad_4x4_i,
  input  logic [2*NG*SAD_W-1:0]    sad_8x4_i,
  input  logic [4*NG*SAD_W-1:0]    sad_4x8_i,
  input  logic [2*NG*SAD_W-1:0]    sad_8x8_i,
  input  logic [NG*SAD_W-1:0]      sad_16x8_i,
  input  logic [2*NG*SAD_W-1:0]    sad_8x16_i,
  input  logic [NG*SAD_W-1:0]      sad_16x16_i,
  output logic                     done_o,
  output logic [NUM_BLK*SAD_W-1:0] min_sad_o,
  output logic [NUM_BLK*MVW-1:0]   min_mvx_o,
  output logic [NUM_BLK*MVW-1:0]   min_mvy_o
);
  localparam int W = SAD_W;

  logic                  step;
  logic [ROW_W-1:0]      row;
  logic signed [MVW-1:0] base_x, base_y;

  smt_cand_seq #(.NG(NG), .SRCH_W(SRCH_W), .SRCH_H(SRCH_H), .MVW(MVW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .run_i    (run_i),
    .step_o   (step),
    .row_o    (row),
    .base_x_o (base_x),
    .base_y_o (base_y),
    .done_o   (done_o)
  );

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(4), .CAD(CAD_4)) u_4x4 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_4x4_i),
    .min_sad_o(min_sad_o[BASE_4X4*W +: 16*W]),
    .min_mvx_o(min_mvx_o[BASE_4X4*MVW +: 16*MVW]),
    .min_mvy_o(min_mvy_o[BASE_4X4*MVW +: 16*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(2), .CAD(CAD_4)) u_8x4 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_8x4_i),
    .min_sad_o(min_sad_o[BASE_8X4*W +: 8*W]),
    .min_mvx_o(min_mvx_o[BASE_8X4*MVW +: 8*MVW]),
    .min_mvy_o(min_mvy_o[BASE_8X4*MVW +: 8*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(4), .CAD(CAD_8)) u_4x8 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_4x8_i),
    .min_sad_o(min_sad_o[BASE_4X8*W +: 8*W]),
    .min_mvx_o(min_mvx_o[BASE_4X8*MVW +: 8*MVW]),
    .min_mvy_o(min_mvy_o[BASE_4X8*MVW +: 8*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(2), .CAD(CAD_8)) u_8x8 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_8x8_i),
    .min_sad_o(min_sad_o[BASE_8X8*W +: 4*W]),
    .min_mvx_o(min_mvx_o[BASE_8X8*MVW +: 4*MVW]),
    .min_mvy_o(min_mvy_o[BASE_8X8*MVW +: 4*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(1), .CAD(CAD_8)) u_16x8 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_16x8_i),
    .min_sad_o(min_sad_o[BASE_16X8*W +: 2*W]),
    .min_mvx_o(min_mvx_o[BASE_16X8*MVW +: 2*MVW]),
    .min_mvy_o(min_mvy_o[BASE_16X8*MVW +: 2*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(2), .CAD(CAD_16)) u_8x16 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_8x16_i),
    .min_sad_o(min_sad_o[BASE_8X16*W +: 2*W]),
    .min_mvx_o(min_mvx_o[BASE_8X16*MVW +: 2*MVW]),
    .min_mvy_o(min_mvy_o[BASE_8X16*MVW +: 2*MVW]));

  smt_shape_unit #(.NG(NG), .W(W), .MVW(MVW), .NT(1), .CAD(CAD_16)) u_16x16 (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .step_i(step), .row_i(row),
    .base_x_i(base_x), .base_y_i(base_y), .sad_i(sad_16x16_i),
    .min_sad_o(min_sad_o[BASE_16X16*W +: W]),
    .min_mvx_o(min_mvx_o[BASE_16X16*MVW +: MVW]),
    .min_mvy_o(min_mvy_o[BASE_16X16*MVW +: MVW]));
endmodule

// File: rtl/smt_checker.sv
module smt_checker
  import smt_pkg::*;
#(
  parameter int SAD_W  = 16,
  parameter int MVW    = 8,
  parameter int SRCH_W = 48,
  parameter int SRCH_H = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     done_o,
  input logic [NUM_BLK*SAD_W-1:0] min_sad_o,
  input logic [NUM_BLK*MVW-1:0]   min_mvx_o,
  input logic [NUM_BLK*MVW-1:0]   min_mvy_o
);
  logic up_q, idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= 1'b0;
    else if (start_i) idle_q <= 1'b0;
    else if (done_o)  idle_q <= 1'b1;
  end

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: start clears every stored SAD and MV
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((&min_sad_o) && (min_mvx_o == '0) && (min_mvy_o == '0)));

  // R10: idle after done keeps outputs frozen
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || idle_q) && !start_i) |=> ($stable(min_sad_o) && $stable(min_mvx_o)
                                         && $stable(min_mvy_o)));

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    // R11: stored SADs never rise outside a start
    a_r11_no_rise: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
      !$past(start_i) |-> (min_sad_o[b*SAD_W +: SAD_W] <= $past(min_sad_o[b*SAD_W +: SAD_W])));

    // R11: horizontal MV stays inside the search window
    a_r11_mvx_range: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'($signed(min_mvx_o[b*MVW +: MVW])) >= -(SRCH_W/2)) &&
       (int'($signed(min_mvx_o[b*MVW +: MVW])) <= SRCH_W/2 - 1)));
  end
endmodule

bind smt_tracker smt_checker #(
  .SAD_W(SAD_W), .MVW(MVW), .SRCH_W(SRCH_W), .SRCH_H(SRCH_H)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .min_sad_o(min_sad_o), .min_mvx_o(min_mvx_o), .min_mvy_o(min_mvy_o)
);

// File: tb/smt_tracker_test.sv
module smt_tracker_test;
  localparam int NG = 16, W = 16, MVW = 8, SW = 48, SH = 32, NB = 41;

  logic clk = 1'b0;
  logic rst_n, start_i, run_i, done_o;
  logic [4*NG*W-1:0] s44, s48;
  logic [2*NG*W-1:0] s84, s88, s816;
  logic [NG*W-1:0]   s168, s1616;
  logic [NB*W-1:0]   min_sad;
  logic [NB*MVW-1:0] mvx, mvy;

  always #2 clk = ~clk;

  smt_tracker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_i),
    .sad_4x4_i(s44), .sad_8x4_i(s84), .sad_4x8_i(s48), .sad_8x8_i(s88),
    .sad_16x8_i(s168), .sad_8x16_i(s816), .sad_16x16_i(s1616),
    .done_o(done_o), .min_sad_o(min_sad), .min_mvx_o(mvx), .min_mvy_o(mvy));

  logic [W-1:0] b_sad [16][NG];

  // Tree order: 0-3 4x4, 4-5 8x4, 6-9 4x8, 10-11 8x8, 12 16x8, 13-14 8x16, 15 16x16 (R5).
  always_comb begin
    for (int g = 0; g < NG; g++) begin
      for (int j = 0; j < 4; j++) begin
        s44[(j*NG+g)*W +: W] = b_sad[j][g];
        s48[(j*NG+g)*W +: W] = b_sad[6+j][g];
      end
      for (int j = 0; j < 2; j++) begin
        s84[(j*NG+g)*W +: W]  = b_sad[4+j][g];
        s88[(j*NG+g)*W +: W]  = b_sad[10+j][g];
        s816[(j*NG+g)*W +: W] = b_sad[13+j][g];
      end
      s168[g*W +: W]  = b_sad[12][g];
      s1616[g*W +: W] = b_sad[15][g];
    end
  end

  int total = 0, bad = 0;
  int e_sad [NB];
  int e_mx [NB];
  int e_my [NB];
  int m_busy = 0, m_row = 0, m_vy = 0, m_ph = 0;
  bit e_done = 0;

  function automatic void tinfo(input int t, output int j, output int nt,
                                output int base, output int kind);
    if (t < 4)       begin j = t;    nt = 4; base = 0;  kind = 0; end
    else if (t < 6)  begin j = t-4;  nt = 2; base = 16; kind = 0; end
    else if (t < 10) begin j = t-6;  nt = 4; base = 24; kind = 1; end
    else if (t < 12) begin j = t-10; nt = 2; base = 32; kind = 1; end
    else if (t == 12) begin j = 0;   nt = 1; base = 36; kind = 1; end
    else if (t < 15) begin j = t-13; nt = 2; base = 38; kind = 2; end
    else             begin j = 0;    nt = 1; base = 40; kind = 2; end
  endfunction

  // R4: does tree t sample on row r, and for which slot
  function automatic bit fires(input int t, input int r, output int slot);
    int j, nt, base, kind;
    tinfo(t, j, nt, base, kind);
    slot = 0;
    if (kind == 0) begin slot = r / 4; return (r % 4) == 3; end
    if (kind == 1) begin slot = r / 8; return (r % 8) == 7; end
    return r == 15;
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin e_sad[b] = 65535; e_mx[b] = 0; e_my[b] = 0; end
  endtask

  // Reference behaviour from R2, R3, R4, R7, R8, R9
  task automatic model_apply(input bit run, input bit start);
    e_done = 0;
    if (start) begin
      m_busy = 1; m_row = 0; m_vy = 0; m_ph = 0;
      model_clear();
    end else if (m_busy != 0 && run) begin
      for (int t = 0; t < 16; t++) begin
        int slot, j, nt, base, kind, blk, best, bg;
        if (fires(t, m_row, slot)) begin
          tinfo(t, j, nt, base, kind);
          blk = base + slot*nt + j;
          best = int'(b_sad[t][0]); bg = 0;
          for (int g = 1; g < NG; g++)
            if (int'(b_sad[t][g]) < best) begin best = int'(b_sad[t][g]); bg = g; end
          if (best < e_sad[blk]) begin
            e_sad[blk] = best;
            e_mx[blk]  = -(SW/2) + m_ph*NG + bg;
            e_my[blk]  = -(SH/2) + m_vy;
          end
        end
      end
      if (m_row == 15) begin
        m_row = 0;
        if (m_vy == SH-1) begin
          m_vy = 0;
          if (m_ph == SW/NG - 1) begin m_ph = 0; m_busy = 0; e_done = 1; end
          else m_ph++;
        end else m_vy++;
      end else m_row++;
    end
  endtask

  // mode 0: constant 100; 1: narrow random; 2: wide random, zero off-slot
  task automatic drive(input int mode);
    for (int t = 0; t < 16; t++) begin
      int slot;
      bit f = fires(t, m_row, slot);
      for (int g = 0; g < NG; g++) begin
        if (mode == 0)      b_sad[t][g] = 16'd100;
        else if (mode == 1) b_sad[t][g] = W'(200 + $urandom_range(0, 31));
        else                b_sad[t][g] = f ? W'(500 + $urandom_range(0, 30000)) : '0;
      end
    end
  endtask

  task automatic tick(input bit run, input bit start, input int mode);
    drive(mode);
    run_i = run; start_i = start;
    model_apply(run, start);
    @(negedge clk);
    total++;
    if (done_o !== e_done) begin
      bad++;
      $display("FAIL R9 done: actual=%0b expected=%0b", done_o, e_done);
    end
  endtask

  task automatic check_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      int as, ax, ay;
      as = int'(min_sad[b*W +: W]);
      ax = int'($signed(mvx[b*MVW +: MVW]));
      ay = int'($signed(mvy[b*MVW +: MVW]));
      total++;
      if (as != e_sad[b] || ax != e_mx[b] || ay != e_my[b]) begin
        bad++;
        $display("FAIL %s blk%0d: actual=%0d,(%0d,%0d) expected=%0d,(%0d,%0d)",
                 tag, b, as, ax, ay, e_sad[b], e_mx[b], e_my[b]);
      end
    end
  endtask

  task automatic run_mb(input int mode, input bit gaps, input string tag);
    tick(1'b0, 1'b1, mode);
    check_all("R2 start clear");
    while (m_busy != 0) tick(gaps ? ($urandom_range(0, 3) != 0) : 1'b1, 1'b0, mode);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; run_i = 1'b0;
    for (int t = 0; t < 16; t++) for (int g = 0; g < NG; g++) b_sad[t][g] = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    total++;
    if (done_o !== 1'b0) begin bad++; $display("FAIL R1 done: actual=%0b expected=0", done_o); end
    rst_n = 1'b1;
    @(negedge clk);
    // R3: run before any start changes nothing (tracker idle)
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 2);
    check_all("R10 idle before start");
    // R7 R8: all equal -> first candidate, group 0 wins
    run_mb(0, 1'b0, "R7 R8 constant");
    total++;
    if (int'($signed(mvx[40*MVW +: MVW])) != -(SW/2)) begin
      bad++; $display("FAIL R8 tie: actual=%0d expected=%0d",
                      $signed(mvx[40*MVW +: MVW]), -(SW/2));
    end
    // R3 R6: narrow random with stalls
    run_mb(1, 1'b1, "R3 R6 narrow");
    // R4 R5: wide random, zero off-slot lanes
    run_mb(2, 1'b0, "R4 R5 offslot");
    // R10: extra run cycles after done change nothing
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 1);
    check_all("R10 after done");
    // R2: restart mid-run
    tick(1'b0, 1'b1, 2);
    for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, 2);
    tick(1'b1, 1'b1, 2);
    check_all("R2 restart");
    run_mb(2, 1'b1, "R3 R4 after restart");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule